// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is the logic core of a universal programmable logic device. Twelve dedicated inputs and ten feedback signals are each expanded into a true and a complement literal, giving 44 literal lines. Each of 132 product terms is the AND of the literals selected by its row of a connection map. A fixed OR stage gathers the first 120 terms into ten sum outputs. Each output uses a different number of terms, so the outputs in the middle can hold larger expressions than those at the edges. The remaining twelve terms leave the block directly as ten per-output enable terms, one global preset term and one global clear term. A macrocell stage outside this block uses them.

The connection map is written one bit at a time through a serial port. It goes into a shadow copy, and the shadow is applied to the array only when a commit strobe arrives, so the logic never sees a half-written map. A readback port returns any row of the applied map. A lock flag blanks readback and freezes the map. Only a bulk erase clears the lock, and the erase also returns every connection bit to the intact state.

Top module: `pld_sop_array`

## Requirements
- R1: Literal 2s is the true value and literal 2s+1 is the complement of signal s. Signals 0..11 are `ded_in[0..11]` and signals 12..21 are `fb_in[0..9]`. A connection bit of 1 means intact and 0 means open. A product term is the AND of all literals whose bit is intact.
- R2: A product term whose 44 connection bits are all open evaluates true for every input value.
- R3: A product term that has both literals of one signal intact evaluates false for every input value.
- R4: `sum_out[o]` is the OR of a consecutive run of terms starting at term 0. The run lengths for outputs 0..9 are 8, 10, 12, 14, 16, 16, 14, 12, 10 and 8 (terms 0..119).
- R5: Term 120+o drives `oe_term[o]`, term 130 drives `preset_term` and term 131 drives `clear_term`.
- R6: The map is loaded as a 5808-bit stream, most significant bit first. Stream bit b lands in term b/44, literal b%44, so the first bit sent is term 131 literal 43 and the last is term 0 literal 0.
- R7: Shifting with `cfg_shift` changes only the shadow copy. The outputs keep following the applied map until a `cfg_done` cycle, which copies the shadow into the applied map from the next cycle on.
- R8: `rb_row` returns the applied row selected by `rb_sel`. A selection of 132 or above returns all zeros.
- R9: After a `lock_set` cycle, `rb_row` reads all zeros and both `cfg_shift` and `cfg_done` are ignored.
- R10: A `bulk_erase` cycle clears the lock and sets every bit of both map copies to intact. It takes priority over shift, commit and lock requests in the same cycle.
- R11: Reset leaves both copies all intact and the lock clear, so every term output and every sum output is 0.
- R12: Term and sum outputs are combinational, so they follow `ded_in` and `fb_in` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the map storage |
| rst_n | input | 1 | Active-low synchronous reset |
| ded_in | input | 12 | Dedicated input signals |
| fb_in | input | 10 | Feedback signals from the macrocells |
| cfg_shift | input | 1 | Shift one map bit into the shadow copy |
| cfg_bit | input | 1 | Serial map bit |
| cfg_done | input | 1 | Commit the shadow copy to the applied map |
| lock_set | input | 1 | Set the readback and load lock |
| bulk_erase | input | 1 | Clear the lock and set all connections intact |
| rb_sel | input | 8 | Term row selected for readback |
| rb_row | output | 44 | Connection bits of the selected applied row |
| sum_out | output | 10 | OR sums, one per output |
| oe_term | output | 10 | Per-output enable terms |
| preset_term | output | 1 | Global preset term |
| clear_term | output | 1 | Global clear term |

## Verification
The hold properties are checked only in cycles where `ded_in` and `fb_in` are the same at two consecutive edges. They rest on the assumption that the applied map changes only through a commit or an erase. For that reason the stimulus changes inputs only on falling edges, holds every vector for whole cycles, and sometimes repeats a vector so that these properties get exercised. The erase and lock properties place no constraint on the inputs. The bench therefore pulses erase in the same cycle as shift, commit and lock requests.

// File: rtl/pld_pkg.sv
package pld_pkg;
  parameter int N_DED    = 12;
  parameter int N_OUT    = 10;
  parameter int MIN_GRP  = 8;
  parameter int GRP_STEP = 2;

  localparam int N_SIG = N_DED + N_OUT;
  localparam int N_LIT = 2 * N_SIG;

  // number of sum terms feeding output o: grows toward the middle
  function automatic int grp_size(input int o);
    int m;
    m = (o < N_OUT / 2) ? o : (N_OUT - 1 - o);
    return MIN_GRP + GRP_STEP * m;
  endfunction

  // index of the first sum term feeding output o
  function automatic int grp_base(input int o);
    int acc;
    acc = 0;
    for (int k = 0; k < o; k++) acc += grp_size(k);
    return acc;
  endfunction

  localparam int N_SUM    = grp_base(N_OUT);
  localparam int TERM_OE0 = N_SUM;
  localparam int TERM_PRE = N_SUM + N_OUT;
  localparam int TERM_CLR = TERM_PRE + 1;
  localparam int N_TERM   = TERM_CLR + 1;
  localparam int SEL_W    = $clog2(N_TERM + 1);
  localparam int MAP_BITS = N_LIT * N_TERM;

  typedef logic [N_LIT-1:0]  lit_vec_t;
  typedef logic [N_TERM-1:0] term_vec_t;
  typedef logic [N_OUT-1:0]  out_vec_t;

  // literal 2s = true of signal s, 2s+1 = complement
  function automatic lit_vec_t expand_lits(input logic [N_DED-1:0] ded,
                                           input logic [N_OUT-1:0] fb);
    logic [N_SIG-1:0] sig;
    lit_vec_t v;
    sig = {fb, ded};
    for (int s = 0; s < N_SIG; s++) begin
      v[2*s]   = sig[s];
      v[2*s+1] = ~sig[s];
    end
    return v;
  endfunction

  // AND of every literal whose connection bit is intact (1)
  function automatic logic term_eval(input lit_vec_t conn, input lit_vec_t lits);
    return &(~conn | lits);
  endfunction
endpackage

// File: rtl/pld_cfg_store.sv
module pld_cfg_store
  import pld_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             shift_bit,
  input  logic             commit,
  input  logic             lock_req,
  input  logic             erase,
  input  logic [SEL_W-1:0] rb_sel,
  output lit_vec_t         rb_row,
  output logic             locked,
  output lit_vec_t         act_map [N_TERM]
);
  lit_vec_t shadow [N_TERM];
  logic     chain_in [N_TERM];
  logic     shift_fire;
  logic     commit_fire;

  assign shift_fire  = shift_en & ~locked & ~erase;
  assign commit_fire = commit & ~locked & ~erase;

  // rows form one long shift chain: the stream enters row 0, bit 0
  genvar t;
  generate
    for (t = 0; t < N_TERM; t++) begin : g_row
      if (t == 0) begin : g_head
        assign chain_in[t] = shift_bit;
      end else begin : g_link
        assign chain_in[t] = shadow[t-1][N_LIT-1];
      end

      always_ff @(posedge clk) begin
        if (!rst_n || erase) begin
          shadow[t] <= '1;
        end else if (shift_fire) begin
          shadow[t] <= {shadow[t][N_LIT-2:0], chain_in[t]};
        end
      end

      always_ff @(posedge clk) begin
        if (!rst_n || erase) begin
          act_map[t] <= '1;
        end else if (commit_fire) begin
          act_map[t] <= shadow[t];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || erase) begin
      locked <= 1'b0;
    end else if (lock_req) begin
      locked <= 1'b1;
    end
  end

  always_comb begin
    if (locked || (rb_sel >= SEL_W'(N_TERM))) begin
      rb_row = '0;
    end else begin
      rb_row = act_map[rb_sel];
    end
  end
endmodule

// File: rtl/pld_and_plane.sv
module pld_and_plane
  import pld_pkg::*;
(
  input  lit_vec_t  lits,
  input  lit_vec_t  conn [N_TERM],
  output term_vec_t terms
);
  genvar t;
  generate
    for (t = 0; t < N_TERM; t++) begin : g_term
      assign terms[t] = term_eval(conn[t], lits);
    end
  endgenerate
endmodule

// File: rtl/pld_or_plane.sv
module pld_or_plane
  import pld_pkg::*;
(
  input  term_vec_t terms,
  output out_vec_t  sums,
  output out_vec_t  oe,
  output logic      preset,
  output logic      clear
);
  genvar o;
  generate
    for (o = 0; o < N_OUT; o++) begin : g_sum
      localparam int BASE = grp_base(o);
      localparam int SIZE = grp_size(o);
      assign sums[o] = |terms[BASE +: SIZE];
      assign oe[o]   = terms[TERM_OE0 + o];
    end
  endgenerate

  assign preset = terms[TERM_PRE];
  assign clear  = terms[TERM_CLR];
endmodule

// File: rtl/pld_sop_array.sv
module pld_sop_array
  import pld_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DED-1:0] ded_in,
  input  logic [N_OUT-1:0] fb_in,
  input  logic             cfg_shift,
  input  logic             cfg_bit,
  input  logic             cfg_done,
  input  logic             lock_set,
  input  logic             bulk_erase,
  input  logic [SEL_W-1:0] rb_sel,
  output logic [N_LIT-1:0] rb_row,
  output logic [N_OUT-1:0] sum_out,
  output logic [N_OUT-1:0] oe_term,
  output logic             preset_term,
  output logic             clear_term
);
  lit_vec_t  lit_lines;
  lit_vec_t  applied_map [N_TERM];
  term_vec_t term_lines;
  logic      sec_locked;

  assign lit_lines = expand_lits(ded_in, fb_in);

  pld_cfg_store u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (cfg_shift),
    .shift_bit (cfg_bit),
    .commit    (cfg_done),
    .lock_req  (lock_set),
    .erase     (bulk_erase),
    .rb_sel    (rb_sel),
    .rb_row    (rb_row),
    .locked    (sec_locked),
    .act_map   (applied_map)
  );

  pld_and_plane u_and (
    .lits  (lit_lines),
    .conn  (applied_map),
    .terms (term_lines)
  );

  pld_or_plane u_or (
    .terms  (term_lines),
    .sums   (sum_out),
    .oe     (oe_term),
    .preset (preset_term),
    .clear  (clear_term)
  );
endmodule

// File: rtl/pld_sop_chk.sv
module pld_sop_chk
  import pld_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [N_DED-1:0] ded_in,
  input logic [N_OUT-1:0] fb_in,
  input logic             cfg_done,
  input logic             bulk_erase,
  input logic             sec_locked,
  input logic [N_LIT-1:0] rb_row,
  input logic [N_OUT-1:0] sum_out,
  input logic [N_OUT-1:0] oe_term,
  input logic             preset_term,
  input logic             clear_term
);
  p_rb_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sec_locked |-> (rb_row == '0));

  p_erase_unlock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bulk_erase |=> !sec_locked);

  p_erase_all_false_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bulk_erase |=> (sum_out == '0 && oe_term == '0 && !preset_term && !clear_term));

  p_hold_until_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_done && !bulk_erase) ##1 ($stable(ded_in) && $stable(fb_in))
    |-> ($stable(sum_out) && $stable(oe_term) && $stable(preset_term) && $stable(clear_term)));

  p_locked_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_locked && !bulk_erase) ##1 ($stable(ded_in) && $stable(fb_in))
    |-> ($stable(sum_out) && $stable(oe_term)));
endmodule

bind pld_sop_array pld_sop_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ded_in      (ded_in),
  .fb_in       (fb_in),
  .cfg_done    (cfg_done),
  .bulk_erase  (bulk_erase),
  .sec_locked  (sec_locked),
  .rb_row      (rb_row),
  .sum_out     (sum_out),
  .oe_term     (oe_term),
  .preset_term (preset_term),
  .clear_term  (clear_term)
);

// File: tb/pld_sop_array_tb.sv
module pld_sop_array_tb;
  import pld_pkg::*;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N_DED-1:0] ded_in = '0;
  logic [N_OUT-1:0] fb_in = '0;
  logic             cfg_shift = 1'b0, cfg_bit = 1'b0, cfg_done = 1'b0;
  logic             lock_set = 1'b0, bulk_erase = 1'b0;
  logic [SEL_W-1:0] rb_sel = '0;
  logic [N_LIT-1:0] rb_row;
  logic [N_OUT-1:0] sum_out, oe_term;
  logic             preset_term, clear_term;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  lit_vec_t em_act  [N_TERM];
  lit_vec_t em_shad [N_TERM];
  lit_vec_t nxt     [N_TERM];
  bit       em_lock;
  int       grp_len [N_OUT] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};

  always #2 clk = ~clk;

  pld_sop_array u_dut (
    .clk(clk), .rst_n(rst_n), .ded_in(ded_in), .fb_in(fb_in),
    .cfg_shift(cfg_shift), .cfg_bit(cfg_bit), .cfg_done(cfg_done),
    .lock_set(lock_set), .bulk_erase(bulk_erase), .rb_sel(rb_sel),
    .rb_row(rb_row), .sum_out(sum_out), .oe_term(oe_term),
    .preset_term(preset_term), .clear_term(clear_term)
  );

  // expected {preset, clear, oe, sums} from the applied map model
  function automatic logic [2*N_OUT+1:0] model_eval(input logic [N_DED-1:0] d,
                                                    input logic [N_OUT-1:0] f);
    logic [N_TERM-1:0] tv;
    logic [N_OUT-1:0]  sm;
    int base;
    for (int t = 0; t < N_TERM; t++) begin
      tv[t] = 1'b1;
      for (int i = 0; i < N_LIT; i++) begin
        if (em_act[t][i]) begin
          int s;
          logic v;
          s = i / 2;
          v = (s < N_DED) ? d[s] : f[s - N_DED];
          if (i % 2 == 1) v = ~v;
          if (!v) tv[t] = 1'b0;
        end
      end
    end
    base = 0;
    sm = '0;
    for (int o = 0; o < N_OUT; o++) begin
      for (int k = 0; k < grp_len[o]; k++) if (tv[base + k]) sm[o] = 1'b1;
      base += grp_len[o];
    end
    return {tv[120 + N_OUT], tv[121 + N_OUT], tv[120 +: N_OUT], sm};
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [N_DED-1:0] d, input logic [N_OUT-1:0] f, input string tag);
    @(negedge clk);
    ded_in = d;
    fb_in  = f;
    #1;
    check(tag, 64'({preset_term, clear_term, oe_term, sum_out}), 64'(model_eval(d, f)));
  endtask

  task automatic random_vectors(input int n, input string tag);
    logic [N_DED-1:0] d;
    logic [N_OUT-1:0] f;
    d = '0;
    f = '0;
    for (int k = 0; k < n; k++) begin
      if (($urandom % 4) != 0) begin
        d = N_DED'($urandom);
        f = N_OUT'($urandom);
      end
      apply(d, f, tag);
    end
  endtask

  task automatic check_rb(input int sel, input lit_vec_t exp, input string tag);
    @(negedge clk);
    rb_sel = SEL_W'(sel);
    #1;
    check(tag, 64'(rb_row), 64'(exp));
  endtask

  task automatic gen_map();
    for (int t = 0; t < N_TERM; t++) begin
      int r;
      r = $urandom % 100;
      nxt[t] = '0;
      if (r < 45) begin
        int s;
        s = $urandom % N_SIG;
        nxt[t][2*s] = 1'b1;
        nxt[t][2*s+1] = 1'b1;
        nxt[t][$urandom % N_LIT] = 1'b1;
      end else if (r < 97) begin
        int n;
        n = 1 + ($urandom % 3);
        for (int j = 0; j < n; j++) nxt[t][$urandom % N_LIT] = 1'b1;
      end
    end
  endtask

  // stream nxt in, most significant stream bit first; optionally commit
  task automatic load_map(input bit commit);
    for (int b = MAP_BITS - 1; b >= 0; b--) begin
      @(negedge clk);
      cfg_shift = 1'b1;
      cfg_bit = nxt[b / N_LIT][b % N_LIT];
    end
    @(negedge clk);
    cfg_shift = 1'b0;
    if (!em_lock) for (int t = 0; t < N_TERM; t++) em_shad[t] = nxt[t];
    if (commit) begin
      cfg_done = 1'b1;
      @(negedge clk);
      cfg_done = 1'b0;
      if (!em_lock) for (int t = 0; t < N_TERM; t++) em_act[t] = em_shad[t];
    end
  endtask

  task automatic commit_only();
    @(negedge clk);
    cfg_done = 1'b1;
    @(negedge clk);
    cfg_done = 1'b0;
    if (!em_lock) for (int t = 0; t < N_TERM; t++) em_act[t] = em_shad[t];
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_22A1));
    for (int t = 0; t < N_TERM; t++) begin
      em_act[t] = '1;
      em_shad[t] = '1;
    end
    em_lock = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state, everything intact, all outputs low
    check_rb(0, '1, "R11 rb row 0");
    check_rb(N_TERM - 1, '1, "R11 rb row 131");
    apply(12'hA5C, 10'h2B3, "R11 outputs");

    // directed map: R1, R2, R3
    for (int t = 0; t < N_TERM; t++) nxt[t] = '1;
    nxt[0] = '0;                              // open -> true (R2)
    nxt[8] = lit_vec_t'(1) << 0;              // ded_in[0] true literal (R1)
    nxt[18] = (lit_vec_t'(1) << 24) | (lit_vec_t'(1) << 23); // fb[0] & ~ded[11] (R1)
    nxt[19] = (lit_vec_t'(1) << 6) | (lit_vec_t'(1) << 7);   // pair -> false (R3)
    nxt[120] = lit_vec_t'(1) << 43;           // oe0 = ~fb[9] (R5)
    nxt[130] = '0;                            // preset open (R5)
    load_map(1'b1);
    apply(12'h000, 10'h000, "R1 R2 vec0");
    apply(12'h001, 10'h001, "R1 vec1");
    apply(12'h800, 10'h001, "R1 vec2");
    apply(12'h008, 10'h200, "R3 R5 vec3");
    apply(12'hFFF, 10'h3FF, "R2 R3 vec4");

    // random maps: R4, R5, R12
    for (int m = 0; m < 3; m++) begin
      gen_map();
      load_map(1'b1);
      random_vectors(40, "R4 R5 R12 random");
    end

    // R6, R8: full readback of the applied map, then out-of-range rows
    for (int t = 0; t < N_TERM; t++) check_rb(t, em_act[t], "R6 R8 readback");
    check_rb(N_TERM, '0, "R8 sel 132");
    check_rb(255, '0, "R8 sel 255");

    // R7: shadow changes are invisible until commit
    gen_map();
    load_map(1'b0);
    random_vectors(15, "R7 before commit");
    check_rb(5, em_act[5], "R7 rb before commit");
    commit_only();
    random_vectors(15, "R7 after commit");
    check_rb(5, em_act[5], "R7 rb after commit");

    // R9: lock blanks readback and freezes loads
    @(negedge clk);
    lock_set = 1'b1;
    @(negedge clk);
    lock_set = 1'b0;
    em_lock = 1'b1;
    check_rb(0, '0, "R9 rb blank row 0");
    check_rb(77, '0, "R9 rb blank row 77");
    gen_map();
    load_map(1'b1);
    random_vectors(20, "R9 load ignored");
    check_rb(3, '0, "R9 rb still blank");

    // R10: erase beats shift, commit and lock in the same cycle
    @(negedge clk);
    bulk_erase = 1'b1;
    cfg_shift = 1'b1;
    cfg_done = 1'b1;
    lock_set = 1'b1;
    @(negedge clk);
    bulk_erase = 1'b0;
    cfg_shift = 1'b0;
    cfg_done = 1'b0;
    lock_set = 1'b0;
    em_lock = 1'b0;
    for (int t = 0; t < N_TERM; t++) begin
      em_act[t] = '1;
      em_shad[t] = '1;
    end
    check_rb(0, '1, "R10 rb intact row 0");
    check_rb(130, '1, "R10 rb intact row 130");
    random_vectors(10, "R10 outputs after erase");
    commit_only();
    random_vectors(5, "R10 shadow also intact");
    gen_map();
    load_map(1'b1);
    random_vectors(20, "R10 load after erase");
    check_rb(64, em_act[64], "R10 rb after reload");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule